// File: doc/BRIEF.md
# Missing Injection Pulse Detector

This block watches a single injector or spark-command line together with a crank-angle word and confirms that every engine cycle contains at least one pulse. Each incoming pulse is brought into the clock domain through two flip-flops. Its rising edge marks the cycle in progress as "seen". When the crank angle wraps back past zero, the block closes the cycle. If no pulse arrived during that cycle, a fault flag is raised.

The engine cycle is one revolution (360 degrees) or two revolutions (720 degrees), chosen by a mode input. A parameter sets how the angle word is read. In one form the angle runs 0 to 359, and the block counts two wraps for each 720-degree cycle. In the other form the angle runs 0 to 719, and it is used directly: in 360-degree mode the crossing of 360 also closes a cycle. The fault is sticky. Only an active-low clear line removes it, and that line is synchronized before use. The first partial cycle after reset is never judged. One instance serves one channel.

Top module: `miss_pulse_mon`

## Requirements
- R1: While reset is asserted and directly after it, `miss_fault` and `pulse_seen` are 0.
- R2: A rising edge on `pulse_in` sets `pulse_seen`, and it stays 1 until the end of the current engine cycle.
- R3: A cycle boundary is detected when the crank-angle sample is lower than the previous sample, even if the value 0 never appears. At each boundary `pulse_seen` returns to 0.
- R4: At a boundary that closes a cycle with no pulse edge, `miss_fault` becomes 1 on the same clock edge.
- R5: The first partial cycle after reset (up to and including the first boundary) never sets `miss_fault`.
- R6: Once set, `miss_fault` stays 1 through later cycles that contain pulses, for as long as `fault_clr_n` stays high.
- R7: `fault_clr_n` = 0 clears `miss_fault` within three clock cycles. While it is held low, it keeps the flag at 0 even across an empty cycle.
- R8: With `cycle_720` = 1 and a 0..359 angle, a cycle spans two wraps. The first wrap neither judges the cycle nor clears `pulse_seen`. A pulse in either revolution satisfies the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crank_angle | input | ANG_W | Crank angle in degrees, sampled each clock |
| pulse_in | input | 1 | Asynchronous injector or spark command line |
| cycle_720 | input | 1 | 0: cycle is 360 degrees, 1: cycle is 720 degrees |
| fault_clr_n | input | 1 | Asynchronous active-low clear of the sticky fault |
| pulse_seen | output | 1 | A pulse edge has occurred in the current cycle |
| miss_fault | output | 1 | Sticky flag: a cycle closed without a pulse |

## Verification
The properties assume that the crank angle only moves forward between samples, by less than half a cycle. Under that assumption, the only decrease is a true wrap. They also assume that the cycle mode changes only under reset. The stimulus meets both: the angle advances in random steps of 5 to 20 degrees, each wrap lands on a nonzero value, and the mode is switched only while reset is held. Pulses are held for three samples, placed well inside a revolution, so that the synchronizer latency never pushes an edge across a boundary.

// File: rtl/mpd_pkg.sv
package mpd_pkg;
   localparam int DEG_REV   = 360;
   localparam int DEG_CYCLE = 720;

   typedef enum logic {
      CYC_ONE_REV = 1'b0,
      CYC_TWO_REV = 1'b1
   } cyc_mode_e;
endpackage

// File: rtl/mpd_sync_edge.sv
module mpd_sync_edge #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mpd_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= {(STAGES+1){RESET_VAL}};
      else        sh <= {sh[STAGES-1:0], d};
   end

   assign q    = sh[STAGES-1];
   assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/mpd_wrap_detect.sv
module mpd_wrap_detect
   import mpd_pkg::*;
#(
   parameter int ANG_W      = 10,
   parameter bit DIRECT_720 = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ANG_W-1:0] angle,
   input  logic             mode_720,
   output logic             boundary
);
   localparam int NEED_W = DIRECT_720 ? $clog2(DEG_CYCLE) : $clog2(DEG_REV);
   localparam logic [ANG_W-1:0] HALF_MARK = ANG_W'(DEG_REV);

   if (ANG_W < NEED_W) begin : g_bad_width
      $error("mpd_wrap_detect: ANG_W too narrow for the angle range");
   end

   logic [ANG_W-1:0] prev_q;
   logic             prev_vld;
   logic             wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= '0;
         prev_vld <= 1'b0;
      end else begin
         prev_q   <= angle;
         prev_vld <= 1'b1;
      end
   end

   assign wrap = prev_vld && (angle < prev_q);

   if (DIRECT_720) begin : g_direct
      logic cross_half;
      assign cross_half = prev_vld && (prev_q < HALF_MARK) && (angle >= HALF_MARK);
      assign boundary   = mode_720 ? wrap : (wrap | cross_half);
   end else begin : g_two_wrap
      logic half_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        half_q <= 1'b0;
         else if (!mode_720) half_q <= 1'b0;
         else if (wrap)      half_q <= ~half_q;
      end
      assign boundary = wrap && (!mode_720 || half_q);
   end
endmodule

// File: rtl/mpd_window.sv
module mpd_window (
   input  logic clk,
   input  logic rst_n,
   input  logic boundary,
   input  logic pulse_rise,
   input  logic clr_q,
   output logic seen,
   output logic armed,
   output logic fault
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen  <= 1'b0;
         armed <= 1'b0;
      end else if (boundary) begin
         seen  <= pulse_rise;
         armed <= 1'b1;
      end else if (pulse_rise) begin
         seen  <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          fault <= 1'b0;
      else if (!clr_q)                     fault <= 1'b0;
      else if (boundary && armed && !seen) fault <= 1'b1;
   end
endmodule

// File: rtl/miss_pulse_mon.sv
module miss_pulse_mon
   import mpd_pkg::*;
#(
   parameter int ANG_W      = 10,
   parameter bit DIRECT_720 = 1'b0,
   parameter int SYNC_DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ANG_W-1:0] crank_angle,
   input  logic             pulse_in,
   input  logic             cycle_720,
   input  logic             fault_clr_n,
   output logic             pulse_seen,
   output logic             miss_fault
);
   logic      cyc_boundary;
   logic      pulse_rise;
   logic      pulse_lvl;
   logic      clr_q;
   logic      clr_fall;
   logic      win_armed;
   cyc_mode_e mode;

   assign mode = cyc_mode_e'(cycle_720);

   mpd_sync_edge #(.STAGES(SYNC_DEPTH), .RESET_VAL(1'b0)) u_pulse_sync (
      .clk(clk), .rst_n(rst_n), .d(pulse_in), .q(pulse_lvl), .rise(pulse_rise)
   );

   mpd_sync_edge #(.STAGES(SYNC_DEPTH), .RESET_VAL(1'b1)) u_clr_sync (
      .clk(clk), .rst_n(rst_n), .d(fault_clr_n), .q(clr_q), .rise(clr_fall)
   );

   mpd_wrap_detect #(.ANG_W(ANG_W), .DIRECT_720(DIRECT_720)) u_wrap (
      .clk(clk), .rst_n(rst_n), .angle(crank_angle),
      .mode_720(mode == CYC_TWO_REV), .boundary(cyc_boundary)
   );

   mpd_window u_win (
      .clk(clk), .rst_n(rst_n), .boundary(cyc_boundary), .pulse_rise(pulse_rise),
      .clr_q(clr_q), .seen(pulse_seen), .armed(win_armed), .fault(miss_fault)
   );

   logic unused_ok;
   assign unused_ok = pulse_lvl ^ clr_fall;
endmodule

// File: rtl/mpd_checker.sv
module mpd_checker (
   input logic clk,
   input logic rst_n,
   input logic boundary,
   input logic pulse_rise,
   input logic clr_q,
   input logic seen,
   input logic armed,
   input logic fault
);
   p_seen_needs_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !seen && !pulse_rise |=> !seen);

   p_seen_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      seen && !boundary |=> seen);

   p_boundary_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      boundary && !pulse_rise |=> !seen);

   p_miss_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      boundary && armed && !seen && clr_q |=> fault);

   p_set_at_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !fault && !boundary |=> !fault);

   p_unarmed_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !armed && !fault |=> !fault);

   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fault && clr_q |=> fault);

   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_q |=> !fault);
endmodule

bind miss_pulse_mon mpd_checker u_chk (
   .clk(clk), .rst_n(rst_n), .boundary(cyc_boundary), .pulse_rise(pulse_rise),
   .clr_q(clr_q), .seen(pulse_seen), .armed(win_armed), .fault(miss_fault)
);

// File: tb/sim_miss_pulse_mon.sv
module sim_miss_pulse_mon;
   localparam int AW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] crank = '0;
   logic          pulse_in = 1'b0;
   logic          cyc720 = 1'b0;
   logic          clr_n = 1'b1;
   logic          seen;
   logic          fault;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   int ang = 0;
   bit exp_fault = 1'b0;
   bit armed_m = 1'b0;
   int seed_dummy;

   always #4 clk = ~clk;

   miss_pulse_mon #(.ANG_W(AW), .DIRECT_720(1'b0), .SYNC_DEPTH(2)) u0 (
      .clk(clk), .rst_n(rst_n), .crank_angle(crank), .pulse_in(pulse_in),
      .cycle_720(cyc720), .fault_clr_n(clr_n), .pulse_seen(seen), .miss_fault(fault)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
      end
   endtask

   function automatic bit next_fault(bit armed, bit pulsed, bit prev, bit clearing);
      if (clearing) return 1'b0;
      return prev | (armed & ~pulsed);
   endfunction

   function automatic int next_ang(int a, int st);
      int n = (a + st) % 360;
      if (n == 0) n = 1;   // R3: zero itself is never presented
      return n;
   endfunction

   task automatic step(input int v);
      @(negedge clk);
      crank = AW'(v);
   endtask

   // one revolution ending just after the wrapping sample has been clocked
   task automatic rev(input bit put_pulse, input int exp_seen);
      int  hold = 0;
      bit  fired = 1'b0;
      bit  wrapped = 1'b0;
      while (!wrapped) begin
         int st = 5 + int'($urandom_range(15));
         int n = next_ang(ang, st);
         if (n < ang) begin
            if (exp_seen >= 0) chk("R2 pulse_seen before boundary", seen, exp_seen[0]);
            wrapped = 1'b1;
         end
         if (put_pulse && !fired && n >= 150 && !wrapped) begin
            pulse_in = 1'b1;
            fired = 1'b1;
            hold = 3;
         end else if (hold > 0) begin
            hold--;
            if (hold == 0) pulse_in = 1'b0;
         end
         ang = n;
         step(n);
      end
      @(negedge clk);
   endtask

   task automatic run_cycle(input bit pulsed, input bit clearing, input string tag);
      if (cyc720) begin
         bit second = bit'($urandom_range(1));
         rev(pulsed && !second, -1);
         chk("R8 first wrap does not judge", fault, exp_fault);
         chk("R8 first wrap keeps pulse_seen", seen, pulsed && !second);
         rev(pulsed && second, int'(pulsed));
      end else begin
         rev(pulsed, int'(pulsed));
      end
      exp_fault = next_fault(armed_m, pulsed, exp_fault, clearing);
      armed_m = 1'b1;
      chk(tag, fault, exp_fault);
      chk("R3 pulse_seen cleared at boundary", seen, 1'b0);
   endtask

   task automatic run_phase(input bit mode);
      @(negedge clk);
      rst_n = 1'b0;
      cyc720 = mode;
      ang = 100;
      crank = AW'(100);
      repeat (3) @(negedge clk);
      chk("R1 fault in reset", fault, 1'b0);
      chk("R1 pulse_seen in reset", seen, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 fault after reset", fault, 1'b0);
      armed_m = 1'b0;
      exp_fault = 1'b0;
      run_cycle(1'b0, 1'b0, "R5 partial first cycle");
      for (int i = 0; i < 3; i++) run_cycle(1'b1, 1'b0, "R2 pulsed cycle");
      run_cycle(1'b0, 1'b0, "R4 empty cycle sets fault");
      for (int i = 0; i < 2; i++) run_cycle(1'b1, 1'b0, "R6 fault sticky");
      @(negedge clk);
      clr_n = 1'b0;
      repeat (4) @(negedge clk);
      chk("R7 clear removes fault", fault, 1'b0);
      exp_fault = 1'b0;
      run_cycle(1'b0, 1'b1, "R7 clear held over empty cycle");
      clr_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R7 released clear", fault, 1'b0);
      for (int i = 0; i < 12; i++)
         run_cycle($urandom_range(3) != 0, 1'b0, "R4 random cycle fault");
   endtask

   initial begin
      seed_dummy = $urandom(32'h1d5c);
      run_phase(1'b0);
      run_phase(1'b1);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule